// File: doc/BRIEF.md
# Per-Warp Instruction Buffer and Issue Selector

This block sits between the decode stage and the execution pipelines of a multithreaded core. It keeps a small queue of decoded instructions for each resident warp: two slots per warp by default. Every cycle it chooses at most one warp whose oldest buffered instruction may go, and hands that instruction to the memory, SP or SFU pipeline. An instruction may go only if it is present and marked ready by the scoreboard, its warp is not held at a barrier, and its target pipeline is not stalled. Warps that meet these conditions take turns in round-robin order. The cycle an instruction issues, the block also asks the scoreboard to reserve that instruction's destination register.

The fetch unit watches a per-warp empty flag and refills a warp only when all of its slots have drained. A barrier holds every warp that has arrived at it. When the last warp of the thread block arrives, all of them are let go together.

Top module: `ibuf_issue`

## Requirements
- R1: After a synchronous reset, every warp's buffer is empty, no instruction issues, and no warp is held at the barrier. The round-robin pointer starts so that warp 0 is the first warp considered.
- R2: A fill (`wr_en`) loads the slots selected by `wr_mask` for warp `wr_warp` only when that warp's buffer is empty. Slot k takes bits [k*24 +: 24] of `wr_instr`, packed as {pipe[23:22], dst[21:16], op[15:0]}. A fill aimed at a non-empty warp is ignored and changes no slot.
- R3: `buf_empty[w]` is high exactly when no slot of warp w holds a valid instruction.
- R4: A loaded slot starts not ready and becomes ready one cycle after its `sb_set` bit pulses; bit w*2+k belongs to slot k of warp w. A slot that is not ready never issues.
- R5: Within a warp, slots issue in program order. Slot 1 may issue only when slot 0 holds no valid instruction.
- R6: A warp whose `bar_arrive` bit pulsed is held and cannot issue. It is released, together with all other held warps, one cycle after the pulse that completes arrival of all warps.
- R7: Pipe codes are 0 = memory, 1 = SP, 2 = SFU, and 3 = SFU as well. An instruction whose pipe is stalled (`pipe_stall` bit 0 memory, bit 1 SP, bit 2 SFU) does not issue. It issues once the stall drops.
- R8: Among the warps that may issue, the grant goes to the first one found after the most recently issued warp, wrapping around.
- R9: While `iss_valid` is high, the outputs carry the selected warp and that instruction's pipe, destination and opcode. In the same cycle `rsv_valid` is high, with `rsv_warp`/`rsv_dst` equal to the issued warp and destination.
- R10: At most one instruction issues per cycle. The issued slot is no longer valid from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Fill request from fetch/decode |
| wr_warp | input | 2 | Warp being filled |
| wr_mask | input | 2 | Slots carried by the fill |
| wr_instr | input | 48 | Decoded instructions, slot 0 in the low bits |
| sb_set | input | 8 | Scoreboard ready pulses, one per slot |
| bar_arrive | input | 4 | Barrier arrival pulses, one per warp |
| pipe_stall | input | 3 | Stall per pipeline: memory, SP, SFU |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_warp | output | 2 | Warp of the issued instruction |
| iss_pipe | output | 2 | Target pipeline code |
| iss_dst | output | 6 | Destination register |
| iss_op | output | 16 | Opcode/operand payload |
| buf_empty | output | 4 | Per-warp empty flag for fetch |
| rsv_valid | output | 1 | Destination reservation request |
| rsv_warp | output | 2 | Warp of the reservation |
| rsv_dst | output | 6 | Register to reserve |

## Verification
The bench stalls each pipeline in turn, including the alias code 3. A design that decoded the stall lane wrongly would either issue into a stalled pipeline or hold an instruction bound for a free one. It makes slot 1 ready before slot 0, so a design that picked any ready slot instead of the oldest one would issue out of order. It sends a second fill to a warp that is not yet empty; a design that took that fill would issue the wrong opcode or leave an extra instruction behind. It also starts the barrier and round-robin tests from known pointer positions, so a premature barrier release or a grant that repeats the last warp shows up as the wrong warp ID.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    localparam int IB_REG_W = 6;
    localparam int IB_OP_W  = 16;
    localparam int IB_SLOTS = 2;
    localparam int IB_SLOT_W = (IB_SLOTS > 1) ? $clog2(IB_SLOTS) : 1;

    typedef enum logic [1:0] {
        PIPE_MEM     = 2'd0,
        PIPE_SP      = 2'd1,
        PIPE_SFU     = 2'd2,
        PIPE_SFU_ALT = 2'd3
    } pipe_e;

    typedef struct packed {
        pipe_e               pipe;
        logic [IB_REG_W-1:0] dst;
        logic [IB_OP_W-1:0]  op;
    } instr_t;

    localparam int IB_INSTR_W = $bits(instr_t);

    function automatic logic [1:0] stall_lane(input pipe_e p);
        return (p == PIPE_SFU_ALT) ? 2'd2 : 2'(p);
    endfunction

    function automatic logic lane_stalled(input logic [2:0] stall, input pipe_e p);
        return stall[stall_lane(p)];
    endfunction

endpackage

// File: rtl/ibuf_warp_slots.sv
module ibuf_warp_slots
    import ibuf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [IB_SLOTS-1:0]            load_mask,
    input  logic [IB_SLOTS*IB_INSTR_W-1:0] load_data,
    input  logic [IB_SLOTS-1:0]            rdy_set,
    input  logic                           take,
    output logic                           empty,
    output logic                           head_ok,
    output instr_t                         head
);

    logic [IB_SLOTS-1:0]  vld_q;
    logic [IB_SLOTS-1:0]  rdy_q;
    logic [IB_SLOTS-1:0]  clr;
    instr_t               data_q [IB_SLOTS];
    logic [IB_SLOT_W-1:0] head_idx;
    logic                 head_found;
    logic                 accept;

    // Oldest valid slot is the lowest index
    always_comb begin
        head_idx   = '0;
        head_found = 1'b0;
        for (int s = 0; s < IB_SLOTS; s++) begin
            if (!head_found && vld_q[s]) begin
                head_idx   = IB_SLOT_W'(s);
                head_found = 1'b1;
            end
        end
    end

    always_comb begin
        clr = '0;
        if (take) clr[head_idx] = 1'b1;
    end

    assign empty   = ~|vld_q;
    assign accept  = load && empty;
    assign head_ok = head_found && rdy_q[head_idx];
    assign head    = data_q[head_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rdy_q <= '0;
        end else if (accept) begin
            vld_q <= load_mask;
            rdy_q <= '0;
        end else begin
            vld_q <= vld_q & ~clr;
            rdy_q <= (rdy_q | (rdy_set & vld_q)) & ~clr;
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < IB_SLOTS; s++) begin
            if (accept && load_mask[s])
                data_q[s] <= instr_t'(load_data[s*IB_INSTR_W +: IB_INSTR_W]);
        end
    end

endmodule

// File: rtl/ibuf_barrier.sv
module ibuf_barrier #(
    parameter int NUM_WARPS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] arrive,
    output logic [NUM_WARPS-1:0] hold_q
);

    logic [NUM_WARPS-1:0] hold_nxt;

    assign hold_nxt = hold_q | arrive;

    always_ff @(posedge clk) begin
        if (rst)            hold_q <= '0;
        else if (&hold_nxt) hold_q <= '0;
        else                hold_q <= hold_nxt;
    end

endmodule

// File: rtl/ibuf_rr_arb.sv
module ibuf_rr_arb #(
    parameter int NUM_WARPS = 4,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] req,
    output logic                 gnt_valid,
    output logic [WID_W-1:0]     gnt_idx
);

    logic [WID_W-1:0] last_q;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int off = 1; off <= NUM_WARPS; off++) begin
            int idx;
            idx = (int'(last_q) + off) % NUM_WARPS;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = WID_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            last_q <= WID_W'(NUM_WARPS - 1);
        else if (gnt_valid) last_q <= gnt_idx;
    end

endmodule

// File: rtl/ibuf_issue.sv
module ibuf_issue
    import ibuf_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [WID_W-1:0]                wr_warp,
    input  logic [IB_SLOTS-1:0]             wr_mask,
    input  logic [IB_SLOTS*IB_INSTR_W-1:0]  wr_instr,
    input  logic [NUM_WARPS*IB_SLOTS-1:0]   sb_set,
    input  logic [NUM_WARPS-1:0]            bar_arrive,
    input  logic [2:0]                      pipe_stall,
    output logic                            iss_valid,
    output logic [WID_W-1:0]                iss_warp,
    output logic [1:0]                      iss_pipe,
    output logic [IB_REG_W-1:0]             iss_dst,
    output logic [IB_OP_W-1:0]              iss_op,
    output logic [NUM_WARPS-1:0]            buf_empty,
    output logic                            rsv_valid,
    output logic [WID_W-1:0]                rsv_warp,
    output logic [IB_REG_W-1:0]             rsv_dst
);

    instr_t               heads [NUM_WARPS];
    logic [NUM_WARPS-1:0] head_ok;
    logic [NUM_WARPS-1:0] elig;
    logic [NUM_WARPS-1:0] take;
    logic [NUM_WARPS-1:0] bar_wait_q;
    logic                 gnt_valid;
    logic [WID_W-1:0]     gnt_idx;
    instr_t               sel;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        ibuf_warp_slots u_slots (
            .clk       (clk),
            .rst       (rst),
            .load      (wr_en && (wr_warp == WID_W'(w))),
            .load_mask (wr_mask),
            .load_data (wr_instr),
            .rdy_set   (sb_set[w*IB_SLOTS +: IB_SLOTS]),
            .take      (take[w]),
            .empty     (buf_empty[w]),
            .head_ok   (head_ok[w]),
            .head      (heads[w])
        );

        assign elig[w] = head_ok[w] && !bar_wait_q[w]
                         && !lane_stalled(pipe_stall, heads[w].pipe);
        assign take[w] = gnt_valid && (gnt_idx == WID_W'(w));
    end

    ibuf_barrier #(.NUM_WARPS(NUM_WARPS)) u_bar (
        .clk    (clk),
        .rst    (rst),
        .arrive (bar_arrive),
        .hold_q (bar_wait_q)
    );

    ibuf_rr_arb #(.NUM_WARPS(NUM_WARPS)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (elig),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    assign sel       = heads[gnt_idx];
    assign iss_valid = gnt_valid;
    assign iss_warp  = gnt_idx;
    assign iss_pipe  = sel.pipe;
    assign iss_dst   = sel.dst;
    assign iss_op    = sel.op;
    assign rsv_valid = gnt_valid;
    assign rsv_warp  = gnt_idx;
    assign rsv_dst   = sel.dst;

endmodule

// File: rtl/ibuf_issue_chk.sv
module ibuf_issue_chk
    import ibuf_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [WID_W-1:0]     wr_warp,
    input logic [IB_SLOTS-1:0]  wr_mask,
    input logic [2:0]           pipe_stall,
    input logic                 iss_valid,
    input logic [WID_W-1:0]     iss_warp,
    input logic [1:0]           iss_pipe,
    input logic [NUM_WARPS-1:0] buf_empty,
    input logic [NUM_WARPS-1:0] bar_wait
);

    AST_NO_STALLED_ISSUE: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !lane_stalled(pipe_stall, pipe_e'(iss_pipe))); // R7

    AST_ALL_STALLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&pipe_stall) |-> !iss_valid); // R7

    AST_ISSUE_FROM_FILLED: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !buf_empty[iss_warp]); // R3

    AST_FILL_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (|wr_mask) && buf_empty[wr_warp]) |=> !buf_empty[$past(wr_warp)]); // R2

    AST_BARRIER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !bar_wait[iss_warp]); // R6

endmodule

bind ibuf_issue ibuf_issue_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_warp    (wr_warp),
    .wr_mask    (wr_mask),
    .pipe_stall (pipe_stall),
    .iss_valid  (iss_valid),
    .iss_warp   (iss_warp),
    .iss_pipe   (iss_pipe),
    .buf_empty  (buf_empty),
    .bar_wait   (bar_wait_q)
);

// File: tb/ibuf_issue_tb.sv
`timescale 1ns/1ps
module ibuf_issue_tb;
    import ibuf_pkg::*;

    localparam int NW = 4;
    localparam int WW = 2;

    logic                            clk = 1'b0;
    logic                            rst;
    logic                            wr_en;
    logic [WW-1:0]                   wr_warp;
    logic [IB_SLOTS-1:0]             wr_mask;
    logic [IB_SLOTS*IB_INSTR_W-1:0]  wr_instr;
    logic [NW*IB_SLOTS-1:0]          sb_set;
    logic [NW-1:0]                   bar_arrive;
    logic [2:0]                      pipe_stall;
    logic                            iss_valid;
    logic [WW-1:0]                   iss_warp;
    logic [1:0]                      iss_pipe;
    logic [IB_REG_W-1:0]             iss_dst;
    logic [IB_OP_W-1:0]              iss_op;
    logic [NW-1:0]                   buf_empty;
    logic                            rsv_valid;
    logic [WW-1:0]                   rsv_warp;
    logic [IB_REG_W-1:0]             rsv_dst;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ibuf_issue #(.NUM_WARPS(NW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_warp(wr_warp), .wr_mask(wr_mask),
        .wr_instr(wr_instr), .sb_set(sb_set), .bar_arrive(bar_arrive),
        .pipe_stall(pipe_stall), .iss_valid(iss_valid), .iss_warp(iss_warp),
        .iss_pipe(iss_pipe), .iss_dst(iss_dst), .iss_op(iss_op),
        .buf_empty(buf_empty), .rsv_valid(rsv_valid), .rsv_warp(rsv_warp),
        .rsv_dst(rsv_dst)
    );

    // {warp[29:28], pipe[27:26], dst[25:20], op[19:4], stall[3:1], issues_now[0]}
    localparam logic [29:0] VEC [8] = '{
        {2'd0, 2'd0, 6'd3,  16'h1111, 3'b000, 1'b1},
        {2'd1, 2'd1, 6'd10, 16'h2222, 3'b001, 1'b1},
        {2'd2, 2'd2, 6'd20, 16'h3333, 3'b100, 1'b0},
        {2'd3, 2'd0, 6'd63, 16'h4444, 3'b001, 1'b0},
        {2'd0, 2'd1, 6'd0,  16'hABCD, 3'b010, 1'b0},
        {2'd1, 2'd2, 6'd7,  16'h5555, 3'b011, 1'b1},
        {2'd2, 2'd3, 6'd9,  16'h6666, 3'b100, 1'b0},
        {2'd3, 2'd3, 6'd1,  16'h7777, 3'b011, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [IB_INSTR_W-1:0] mk(input logic [1:0] p,
                                                 input logic [5:0] d,
                                                 input logic [15:0] o);
        return {p, d, o};
    endfunction

    task automatic fill(input int w, input logic [1:0] m,
                        input logic [IB_INSTR_W-1:0] s0,
                        input logic [IB_INSTR_W-1:0] s1);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_warp  = WW'(w);
        wr_mask  = m;
        wr_instr = {s1, s0};
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_warp = 0; wr_mask = 0; wr_instr = 0;
        sb_set = 0; bar_arrive = 0; pipe_stall = 0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "buf_empty", 32'(buf_empty), 32'hF);
        chk("R1", "iss_valid", 32'(iss_valid), 0);

        // R8: after reset warp 0 is granted before warp 1
        fill(1, 2'b01, mk(2'd1, 6'd5, 16'h0B01), '0);
        wr_en = 1'b1; wr_warp = 0; wr_mask = 2'b01; wr_instr = {24'h0, mk(2'd1, 6'd4, 16'h0A01)};
        @(negedge clk);
        wr_en = 1'b0; sb_set = 8'b0000_0101;
        @(negedge clk);
        sb_set = '0; #1;
        chk("R8", "first warp after reset", 32'(iss_warp), 0);
        chk("R8", "first valid", 32'(iss_valid), 1);
        @(negedge clk); #1;
        chk("R8", "second warp", 32'(iss_warp), 1);
        @(negedge clk); #1;
        chk("R10", "drained", 32'(iss_valid), 0);

        // Vector walk: R7 stall gating, R9 fields and reservation, R10 slot clear
        foreach (VEC[i]) begin
            automatic logic [29:0] v = VEC[i];
            automatic int w = int'(v[29:28]);
            fill(w, 2'b01, mk(v[27:26], v[25:20], v[19:4]), '0);
            sb_set = '0;
            sb_set[w*2] = 1'b1;
            @(negedge clk);
            sb_set = '0;
            pipe_stall = v[3:1];
            #1;
            chk("R7", "issue under stall", 32'(iss_valid), 32'(v[0]));
            if (v[0]) begin
                chk("R9", "iss_warp", 32'(iss_warp), 32'(v[29:28]));
                chk("R9", "iss_pipe", 32'(iss_pipe), 32'(v[27:26]));
                chk("R9", "iss_dst",  32'(iss_dst),  32'(v[25:20]));
                chk("R9", "iss_op",   32'(iss_op),   32'(v[19:4]));
                chk("R9", "rsv_valid", 32'(rsv_valid), 1);
                chk("R9", "rsv_warp", 32'(rsv_warp), 32'(v[29:28]));
                chk("R9", "rsv_dst",  32'(rsv_dst),  32'(v[25:20]));
            end
            @(negedge clk);
            pipe_stall = '0;
            #1;
            if (v[0]) chk("R10", "no repeat issue", 32'(iss_valid), 0);
            else begin
                chk("R7", "issues after stall drops", 32'(iss_valid), 1);
                chk("R7", "op after stall", 32'(iss_op), 32'(v[19:4]));
            end
            @(negedge clk); #1;
            chk("R3", "empty after drain", 32'(buf_empty[w]), 1);
            chk("R10", "quiet after drain", 32'(iss_valid), 0);
        end

        // R5: slot 1 ready first must wait behind slot 0
        fill(0, 2'b11, mk(2'd1, 6'd1, 16'hA0A0), mk(2'd1, 6'd2, 16'hA1A1));
        sb_set = 8'b0000_0010;
        @(negedge clk);
        sb_set = 8'b0000_0001;
        #1;
        chk("R5", "slot1 alone blocked", 32'(iss_valid), 0);
        chk("R4", "not ready yet", 32'(buf_empty[0]), 0);
        @(negedge clk);
        sb_set = '0; #1;
        chk("R5", "slot0 first", 32'(iss_op), 32'h0000A0A0);
        @(negedge clk); #1;
        chk("R5", "slot1 second", 32'(iss_op), 32'h0000A1A1);
        @(negedge clk); #1;
        chk("R5", "warp drained", 32'(buf_empty[0]), 1);

        // R4: a slot never made ready does not issue
        fill(2, 2'b01, mk(2'd0, 6'd8, 16'hC0C0), '0);
        repeat (3) @(negedge clk);
        #1;
        chk("R4", "unready holds", 32'(iss_valid), 0);
        sb_set = 8'b0001_0000;
        @(negedge clk);
        sb_set = '0; #1;
        chk("R4", "issues after ready", 32'(iss_op), 32'h0000C0C0);
        @(negedge clk);

        // R2: fill to non-empty warp is ignored
        fill(1, 2'b01, mk(2'd1, 6'd11, 16'hB0B0), '0);
        #1;
        chk("R3", "filled not empty", 32'(buf_empty[1]), 0);
        wr_en = 1'b1; wr_warp = 1; wr_mask = 2'b11;
        wr_instr = {mk(2'd1, 6'd13, 16'hC1C1), mk(2'd1, 6'd12, 16'hC0C0)};
        @(negedge clk);
        wr_en = 1'b0; sb_set = 8'b0000_1100;
        @(negedge clk);
        sb_set = '0; #1;
        chk("R2", "original instr kept", 32'(iss_op), 32'h0000B0B0);
        @(negedge clk); #1;
        chk("R2", "no extra slot", 32'(iss_valid), 0);
        chk("R2", "empty after ignored fill", 32'(buf_empty[1]), 1);

        // R8: last issued warp 1 -> order 2,3,0
        fill(0, 2'b01, mk(2'd1, 6'd20, 16'hD000), '0);
        fill(2, 2'b01, mk(2'd1, 6'd22, 16'hD002), '0);
        fill(3, 2'b01, mk(2'd1, 6'd23, 16'hD003), '0);
        sb_set = 8'b0101_0001;
        @(negedge clk);
        sb_set = '0; #1;
        chk("R8", "rr first", 32'(iss_warp), 2);
        @(negedge clk); #1;
        chk("R8", "rr second", 32'(iss_warp), 3);
        @(negedge clk); #1;
        chk("R8", "rr third", 32'(iss_warp), 0);
        @(negedge clk); #1;
        chk("R10", "rr drained", 32'(iss_valid), 0);

        // R6: barrier holds warp 0 until all four arrive
        fill(0, 2'b01, mk(2'd1, 6'd30, 16'hE000), '0);
        fill(1, 2'b01, mk(2'd1, 6'd31, 16'hE001), '0);
        sb_set = 8'b0000_0101;
        bar_arrive = 4'b0001;
        @(negedge clk);
        sb_set = '0; bar_arrive = '0; #1;
        chk("R6", "free warp issues", 32'(iss_warp), 1);
        @(negedge clk); #1;
        chk("R6", "held warp blocked", 32'(iss_valid), 0);
        bar_arrive = 4'b0110;
        @(negedge clk);
        bar_arrive = '0; #1;
        chk("R6", "partial arrival still held", 32'(iss_valid), 0);
        bar_arrive = 4'b1000;
        @(negedge clk);
        bar_arrive = '0; #1;
        chk("R6", "released warp", 32'(iss_valid), 1);
        chk("R6", "released warp id", 32'(iss_warp), 0);
        @(negedge clk); #1;
        chk("R3", "all empty at end", 32'(buf_empty), 32'hF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule